// File: doc/BRIEF.md
# Frame Length Statistics Classifier

The block watches end-of-frame events from both directions of an Ethernet MAC. Each event gives the frame's byte count, whether its FCS checked good, and, for transmit frames, how long the frame was deferred (in byte times). Two mode inputs set the classification rules. The jumbo bit removes the upper length bound from the validity test. The VLAN-size bit raises the maximum frame length from 1518 to 1522 bytes.

Six saturating counters hold the results, and an interrupt pulse marks each excessive deferral. A clear request walks the counters back to zero, one per clock, and then pulses a done flag. A host reads any counter through an index and data port that has one cycle of latency.

Top module: `frame_len_stats`

## Requirements
- R1: After reset every counter reads 0, and `clr_done` and `defer_irq` are low.
- R2: With `mode_jumbo`=0, a frame with `ev_fcs_ok`=1 and a length from 64 up to the maximum (1518, or 1522 when `mode_vlan`=1) increments the valid counter of its direction. The receive valid counter is index 0 and the transmit valid counter is index 1. Any other frame leaves these counters unchanged.
- R3: With `mode_jumbo`=1, any frame with `ev_fcs_ok`=1 and a length of 64 or more counts as valid, with no upper bound.
- R4: A frame from 1024 up to the maximum inclusive increments the bucket counter of its direction, whatever its FCS flag and the jumbo bit. The receive bucket counter is index 2 and the transmit bucket counter is index 3.
- R5: A receive frame longer than the maximum increments the oversize counter (index 4), whatever its FCS flag and the jumbo bit. A transmit frame never does. A frame shorter than 64 bytes counts neither as valid nor as oversize.
- R6: A transmit event whose `ev_defer` exceeds the maximum increments the excessive-deferral counter (index 5). In the following cycle `defer_irq` is high for exactly one cycle. A receive event never does either.
- R7: A `clr_req` sampled while idle starts a walk that zeroes one counter per cycle over `NCNT`=6 cycles. `clr_done` is then high for one cycle, the cycle after the request edge plus 6. A `clr_req` during a walk is ignored.
- R8: Events sampled on any of the 6 walk edges are dropped, and their interrupt with them. An event sampled on the edge after the walk ends is counted.
- R9: Counters saturate at all ones and never wrap.
- R10: `rd_data` is registered. It shows the counter selected by `rd_idx` at the previous edge, with the value that counter held before that edge. Indices 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_jumbo | input | 1 | Jumbo acceptance mode |
| mode_vlan | input | 1 | Maximum length 1522 instead of 1518 |
| ev_valid | input | 1 | End-of-frame event strobe |
| ev_tx | input | 1 | 1 = transmit event, 0 = receive event |
| ev_len | input | LEN_W | Frame byte count |
| ev_fcs_ok | input | 1 | FCS checked good |
| ev_defer | input | LEN_W | Transmit deferral time in byte times |
| clr_req | input | 1 | Start a clear-all walk |
| clr_done | output | 1 | One-cycle pulse when the walk ends |
| defer_irq | output | 1 | One-cycle excessive-deferral interrupt |
| rd_idx | input | IDX_W | Counter index to read |
| rd_data | output | CNT_W | Counter value, one cycle later |

## Verification
The interesting overlap is an end-of-frame event that lands in the same cycle as a step of the clear walk. The bench drives receive and transmit events on walk edges, including the final one, and drives another event on the edge that follows. It then judges the outcome by reading back through the index port: the dropped events leave no count and no interrupt, and the event after the walk is counted exactly once. A repeated clear request during the walk is judged by the exact cycle in which `clr_done` appears.

// File: rtl/frame_len_stats.sv
module frame_len_stats #(
  parameter int CNT_W    = 32,
  parameter int LEN_W    = 16,
  parameter int MIN_LEN  = 64,
  parameter int STD_MAX  = 1518,
  parameter int VLAN_MAX = 1522,
  parameter int BKT_LO   = 1024,
  localparam int NCNT    = 6,
  localparam int IDX_W   = $clog2(NCNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_jumbo,
  input  logic             mode_vlan,
  input  logic             ev_valid,
  input  logic             ev_tx,
  input  logic [LEN_W-1:0] ev_len,
  input  logic             ev_fcs_ok,
  input  logic [LEN_W-1:0] ev_defer,
  input  logic             clr_req,
  output logic             clr_done,
  output logic             defer_irq,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_data
);

  logic [CNT_W-1:0] cnt [NCNT];
  logic             clr_busy;
  logic [IDX_W-1:0] clr_ptr;
  logic [LEN_W-1:0] max_len;
  logic             len_ok_lo, len_ok_hi, good, in_bkt, take;
  logic [NCNT-1:0]  hit;
  logic [CNT_W-1:0] rd_next;

  assign max_len   = mode_vlan ? LEN_W'(VLAN_MAX) : LEN_W'(STD_MAX);
  assign len_ok_lo = ev_len >= LEN_W'(MIN_LEN);
  assign len_ok_hi = ev_len <= max_len;
  assign good      = ev_fcs_ok && len_ok_lo && (mode_jumbo || len_ok_hi);
  assign in_bkt    = (ev_len >= LEN_W'(BKT_LO)) && len_ok_hi;
  assign take      = ev_valid && !clr_busy;

  assign hit[0] = take && !ev_tx && good;
  assign hit[1] = take &&  ev_tx && good;
  assign hit[2] = take && !ev_tx && in_bkt;
  assign hit[3] = take &&  ev_tx && in_bkt;
  assign hit[4] = take && !ev_tx && !len_ok_hi;
  assign hit[5] = take &&  ev_tx && (ev_defer > max_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NCNT; i++) begin
        if (clr_busy && clr_ptr == IDX_W'(i)) cnt[i] <= '0;
        else if (hit[i] && cnt[i] != '1)     cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_busy <= 1'b0;
      clr_ptr  <= '0;
      clr_done <= 1'b0;
    end else begin
      clr_done <= 1'b0;
      if (!clr_busy) begin
        if (clr_req) begin
          clr_busy <= 1'b1;
          clr_ptr  <= '0;
        end
      end else if (clr_ptr == IDX_W'(NCNT-1)) begin
        clr_busy <= 1'b0;
        clr_done <= 1'b1;
      end else begin
        clr_ptr <= clr_ptr + 1'b1;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCNT; i++)
      if (rd_idx == IDX_W'(i)) rd_next = cnt[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer_irq <= 1'b0;
      rd_data   <= '0;
    end else begin
      defer_irq <= hit[5];
      rd_data   <= rd_next;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> !clr_done);

  p_walk_ignores_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy && clr_ptr != IDX_W'(NCNT-1)) |=> (clr_busy && !clr_done));

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    defer_irq |-> $past(ev_valid && ev_tx && !clr_busy));

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    defer_irq |=> !defer_irq || $past(ev_valid && ev_tx && !clr_busy));

  p_no_irq_in_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> !defer_irq);

  p_unused_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= IDX_W'(NCNT)) |=> (rd_data == '0));

  for (genvar g = 0; g < NCNT; g++) begin : g_mono
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_busy && !clr_req) |=> (cnt[g] >= $past(cnt[g])));
    p_hold_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] == '1 && !clr_busy && !clr_req) |=> (cnt[g] == '1));
  end

endmodule

// File: tb/frame_len_stats_bench.sv
module frame_len_stats_bench;
  localparam int CW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_jumbo = 0, mode_vlan = 0, ev_valid = 0, ev_tx = 0, ev_fcs_ok = 0, clr_req = 0;
  logic [15:0] ev_len = '0, ev_defer = '0;
  logic [2:0] rd_idx = '0;
  logic clr_done, defer_irq;
  logic [CW-1:0] rd_data;

  int total = 0, bad = 0;
  int mdl [6];

  always #4 clk = ~clk;

  frame_len_stats #(.CNT_W(CW)) u_frame_len_stats (
    .clk(clk), .rst_n(rst_n), .mode_jumbo(mode_jumbo), .mode_vlan(mode_vlan),
    .ev_valid(ev_valid), .ev_tx(ev_tx), .ev_len(ev_len), .ev_fcs_ok(ev_fcs_ok),
    .ev_defer(ev_defer), .clr_req(clr_req), .clr_done(clr_done),
    .defer_irq(defer_irq), .rd_idx(rd_idx), .rd_data(rd_data));

  typedef struct packed {
    logic tx; logic jmb; logic vln; logic [15:0] len; logic fcs;
    logic [15:0] dfr; logic [5:0] dlt; logic irq;
  } vec_t;

  // dlt bits: [0] rx valid, [1] tx valid, [2] rx bucket, [3] tx bucket, [4] oversize, [5] excess defer
  localparam vec_t TBL [21] = '{
    '{1'b0,1'b0,1'b0,16'd64,  1'b1,16'd0,   6'b000001,1'b0}, // R2 lower bound
    '{1'b0,1'b0,1'b0,16'd63,  1'b1,16'd0,   6'b000000,1'b0}, // R5 short
    '{1'b0,1'b0,1'b0,16'd1518,1'b1,16'd0,   6'b000101,1'b0}, // R2 R4
    '{1'b0,1'b0,1'b0,16'd1519,1'b1,16'd0,   6'b010000,1'b0}, // R5
    '{1'b0,1'b0,1'b1,16'd1522,1'b1,16'd0,   6'b000101,1'b0}, // R2 vlan
    '{1'b0,1'b0,1'b1,16'd1523,1'b1,16'd0,   6'b010000,1'b0}, // R5 vlan
    '{1'b0,1'b1,1'b0,16'd1519,1'b1,16'd0,   6'b010001,1'b0}, // R3 R5
    '{1'b0,1'b1,1'b0,16'd9000,1'b0,16'd0,   6'b010000,1'b0}, // R3 bad fcs
    '{1'b0,1'b0,1'b0,16'd500, 1'b0,16'd0,   6'b000000,1'b0}, // R2 bad fcs
    '{1'b0,1'b0,1'b0,16'd1100,1'b0,16'd0,   6'b000100,1'b0}, // R4 bad fcs
    '{1'b0,1'b0,1'b0,16'd100, 1'b1,16'd5000,6'b000001,1'b0}, // R6 rx defer
    '{1'b1,1'b0,1'b0,16'd1024,1'b1,16'd0,   6'b001010,1'b0}, // R4 tx
    '{1'b1,1'b0,1'b0,16'd1023,1'b1,16'd0,   6'b000010,1'b0}, // R4 below
    '{1'b1,1'b0,1'b0,16'd100, 1'b1,16'd1519,6'b100010,1'b1}, // R6
    '{1'b1,1'b0,1'b1,16'd100, 1'b1,16'd1519,6'b000010,1'b0}, // R6 vlan
    '{1'b1,1'b0,1'b1,16'd100, 1'b1,16'd1523,6'b100010,1'b1}, // R6 vlan
    '{1'b1,1'b1,1'b1,16'd64,  1'b1,16'd0,   6'b000010,1'b0}, // R3 tx
    '{1'b1,1'b0,1'b0,16'd2000,1'b1,16'd0,   6'b000000,1'b0}, // R5 tx no oversize
    '{1'b0,1'b1,1'b1,16'd40,  1'b1,16'd0,   6'b000000,1'b0}, // R5 short jumbo
    '{1'b1,1'b0,1'b0,16'd1522,1'b1,16'd1518,6'b000000,1'b0}, // R6 at limit
    '{1'b0,1'b0,1'b1,16'd1024,1'b1,16'd0,   6'b000101,1'b0}  // R4 rx
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output int val);
    @(negedge clk) rd_idx = 3'(idx);
    @(negedge clk) val = int'(rd_data);
  endtask

  task automatic send(input vec_t v, output logic irq);
    @(negedge clk);
    mode_jumbo = v.jmb; mode_vlan = v.vln; ev_tx = v.tx; ev_len = v.len;
    ev_fcs_ok = v.fcs; ev_defer = v.dfr; ev_valid = 1'b1;
    @(negedge clk) ev_valid = 1'b0;
    irq = defer_irq;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    logic irq;
    vec_t e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R10 unused indices
    chk("R1 clr_done", int'(clr_done), 0);
    chk("R1 defer_irq", int'(defer_irq), 0);
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      chk(i < 6 ? "R1 counter" : "R10 unused index", v, 0);
    end
    for (int i = 0; i < 6; i++) mdl[i] = 0;

    for (int t = 0; t < 21; t++) begin
      send(TBL[t], irq);
      chk("R6 irq", int'(irq), int'(TBL[t].irq));
      for (int j = 0; j < 6; j++) if (TBL[t].dlt[j]) mdl[j]++;
      for (int j = 0; j < 6; j++) begin
        rd(j, v);
        chk("R2-table counter", v, mdl[j]);
      end
    end
    @(negedge clk);
    chk("R6 irq single pulse", int'(defer_irq), 0);

    // R7 R8 clear walk overlapping events
    @(negedge clk) clr_req = 1'b1;
    @(negedge clk) clr_req = 1'b0;
    chk("R7 done early", int'(clr_done), 0);
    @(negedge clk) clr_req = 1'b1;
    @(negedge clk) clr_req = 1'b0;
    ev_tx = 1'b1; ev_len = 16'd100; ev_fcs_ok = 1'b1; ev_defer = 16'd2000;
    mode_jumbo = 1'b0; mode_vlan = 1'b0; ev_valid = 1'b1;
    @(negedge clk) ev_valid = 1'b0;
    chk("R8 irq dropped in walk", int'(defer_irq), 0);
    @(negedge clk);
    chk("R7 done early", int'(clr_done), 0);
    @(negedge clk) begin
      ev_tx = 1'b0; ev_defer = 16'd0; ev_valid = 1'b1;
    end
    @(negedge clk);
    chk("R7 done timing", int'(clr_done), 1);
    @(negedge clk) ev_valid = 1'b0;
    chk("R7 done pulse", int'(clr_done), 0);
    rd(0, v); chk("R8 after-walk event counted once", v, 1);
    rd(1, v); chk("R8 walk tx event dropped", v, 0);
    for (int j = 2; j < 6; j++) begin
      rd(j, v); chk("R7 cleared", v, 0);
    end
    chk("R7 no restart", int'(clr_done), 0);

    // R9 saturation
    e = '{1'b0,1'b0,1'b0,16'd100,1'b1,16'd0,6'b000001,1'b0};
    @(negedge clk);
    mode_jumbo = e.jmb; mode_vlan = e.vln; ev_tx = e.tx; ev_len = e.len;
    ev_fcs_ok = e.fcs; ev_defer = e.dfr; ev_valid = 1'b1;
    repeat (70) @(negedge clk);
    ev_valid = 1'b0;
    rd(0, v); chk("R9 saturated", v, (1 << CW) - 1);
    rd(2, v); chk("R9 neighbour untouched", v, 0);

    // R10 read shows pre-edge value
    @(negedge clk) begin
      rd_idx = 3'd1; ev_tx = 1'b1; ev_valid = 1'b1;
    end
    @(negedge clk) begin
      ev_valid = 1'b0;
      chk("R10 pre-edge value", int'(rd_data), 0);
    end
    @(negedge clk) chk("R10 next value", int'(rd_data), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule